// File: doc/BRIEF.md
# Infrared Link Mode Configuration Gate

This block sits between a register bus and the infrared encoder/decoder logic. Software writes a pending link configuration and a pending physical-layer parameter word at any time. Neither reaches the line logic until the gate bit goes from 0 to 1. On that edge the pending words are copied into applied registers, which then drive the encoder and decoder outputs. The applied physical-layer word can be read back through a separate read-only register.

While the gate bit is 1, writes to the pending registers are stored but have no effect on the applied state. A new value takes effect only on the next 0-to-1 edge. Clearing the gate bit turns off every mode output at the next clock edge.

A status register reports the following:
- the gate state;
- a configuration error, raised when more than one of the three encoding modes is selected;
- which mode is on;
- live transmit and receive enable indications.

While the error is present, all three mode outputs are held off.

The register port is plain and single-cycle, with no back-pressure. A write is accepted at any clock edge where `wr_en_i` is high. Reads are combinational from `rd_addr_i`. Word offsets are as follows:
- 0: pending link configuration.
- 1: gate and status.
- 2: pending physical-layer word.
- 3: applied physical-layer word.

Top module: `irgate_top`

## Requirements
- R1: After reset, every register reads 0, every mode, enable, polarity and filter output is 0, and the physical-layer outputs are 0.
- R2: The link configuration word (offset 0) stores these bits and reads them back:
  - loopback at bit 14;
  - transmit enable at bit 12;
  - receive enable at bit 11;
  - bus master at bit 10;
  - accept-any at bit 9;
  - 16-bit CRC at bit 7;
  - FIR mode at bit 6;
  - MIR mode at bit 5;
  - SIR mode at bit 4;
  - SIR filter at bit 3;
  - SIR filter test at bit 2;
  - transmit invert at bit 1;
  - receive invert at bit 0.

  Bits 15, 13 and 8 always read 0.
- R3: The pending physical-layer word (offset 2) reads back all 16 bits. Baud divisor is in [15:10], pulse width in [9:5] and preamble count in [4:0]. Writes to offset 3 are ignored.
- R4: On a write that sets gate bit 15 of offset 1 while the gate is 0, the pending words are applied. From the next clock on, offset 3 equals the pending physical-layer word, and the encoder outputs carry the pending configuration fields.
- R5: Writes to offsets 0 and 2 while the gate is 1 change neither offset 3 nor any applied output. They take effect at the next 0-to-1 gate edge.
- R6: The mode outputs and the mode-on status bits (bit 13 FIR, bit 12 MIR, bit 11 SIR) follow the applied mode bits only while the gate is 1. They drop at the clock after the gate is cleared.
- R7: When the gate is 1 and more than one applied mode bit is set, status bit 14 and `cfg_err_o` are 1, and all three mode outputs and mode-on bits are 0.
- R8: Status bit 10 equals the pending transmit enable. Status bit 9 equals pending receive enable AND (NOT pending transmit enable OR pending loopback). Both apply regardless of the gate.
- R9: Offset 1 reads the gate at bit 15 and 16-bit CRC on at bit 8 (gate AND applied CRC bit). Bits [7:0] read 0, and writes to bits other than 15 have no effect.
- R10: While the gate is 1, `tx_en_o` is the applied transmit enable. `rx_en_o` is applied receive enable AND (NOT applied transmit enable OR applied loopback). Both are 0 while the gate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write word offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read word offset |
| rd_data_o | output | 16 | Register read data (combinational) |
| mode_sir_o | output | 1 | SIR encoding active |
| mode_mir_o | output | 1 | MIR encoding active |
| mode_fir_o | output | 1 | FIR encoding active |
| crc16_o | output | 1 | 16-bit CRC selected |
| tx_en_o | output | 1 | Transmit path enabled |
| rx_en_o | output | 1 | Receive path enabled |
| loop_o | output | 1 | Loopback active |
| tx_inv_o | output | 1 | Invert transmit polarity |
| rx_inv_o | output | 1 | Invert receive polarity |
| sir_filt_o | output | 1 | SIR receive unwrapping on |
| sir_filt_any_o | output | 1 | Allow SIR unwrapping outside SIR mode |
| rx_any_o | output | 1 | Accept any received packet |
| bus_master_o | output | 1 | Bus master cycles allowed |
| baud_div_o | output | 6 | Applied baud divisor |
| pulse_w_o | output | 5 | Applied pulse width |
| preamble_o | output | 5 | Applied preamble count |
| cfg_err_o | output | 1 | Conflicting mode selection applied |

## Verification
A wrong applied register shows up at offset 3 and on the physical-layer outputs one clock after the gate edge. It stays wrong until the next edge, so any read after enabling exposes it.

A wrong gate flag or a faulty error decode shows up at the mode outputs and at status bits 14 to 11 in the same cycle. Every combination of the three mode bits is applied in turn, so a decode fault appears within a single enable sequence.

The live transmit and receive status bits are checked both before and after the edge. This separates the pending path from the applied path.

// File: rtl/irgate_pkg.sv
package irgate_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  // register word offsets
  localparam logic [ADDR_W-1:0] OFS_LINK   = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_GATE   = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_NXPHY  = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_CURPHY = 2'd3;

  // link configuration bit positions
  localparam int LB_LOOP    = 14;
  localparam int LB_ENTX    = 12;
  localparam int LB_ENRX    = 11;
  localparam int LB_MSTR    = 10;
  localparam int LB_RXANY   = 9;
  localparam int LB_CRC16   = 7;
  localparam int LB_FIR     = 6;
  localparam int LB_MIR     = 5;
  localparam int LB_SIR     = 4;
  localparam int LB_SIRFILT = 3;
  localparam int LB_SIRTEST = 2;
  localparam int LB_TXINV   = 1;
  localparam int LB_RXINV   = 0;

  // gate/status bit positions
  localparam int SB_GATE  = 15;
  localparam int SB_ERR   = 14;
  localparam int SB_FIRON = 13;
  localparam int SB_MIRON = 12;
  localparam int SB_SIRON = 11;
  localparam int SB_TXST  = 10;
  localparam int SB_RXST  = 9;
  localparam int SB_CRCON = 8;

  typedef struct packed {
    logic loop;
    logic entx;
    logic enrx;
    logic mstr;
    logic rxany;
    logic crc16;
    logic fir;
    logic mir;
    logic sir;
    logic sirfilt;
    logic sirtest;
    logic txinv;
    logic rxinv;
  } link_cfg_t;

  function automatic link_cfg_t unpack_link(input logic [REG_W-1:0] w);
    link_cfg_t c;
    c.loop    = w[LB_LOOP];
    c.entx    = w[LB_ENTX];
    c.enrx    = w[LB_ENRX];
    c.mstr    = w[LB_MSTR];
    c.rxany   = w[LB_RXANY];
    c.crc16   = w[LB_CRC16];
    c.fir     = w[LB_FIR];
    c.mir     = w[LB_MIR];
    c.sir     = w[LB_SIR];
    c.sirfilt = w[LB_SIRFILT];
    c.sirtest = w[LB_SIRTEST];
    c.txinv   = w[LB_TXINV];
    c.rxinv   = w[LB_RXINV];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_link(input link_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[LB_LOOP]    = c.loop;
    w[LB_ENTX]    = c.entx;
    w[LB_ENRX]    = c.enrx;
    w[LB_MSTR]    = c.mstr;
    w[LB_RXANY]   = c.rxany;
    w[LB_CRC16]   = c.crc16;
    w[LB_FIR]     = c.fir;
    w[LB_MIR]     = c.mir;
    w[LB_SIR]     = c.sir;
    w[LB_SIRFILT] = c.sirfilt;
    w[LB_SIRTEST] = c.sirtest;
    w[LB_TXINV]   = c.txinv;
    w[LB_RXINV]   = c.rxinv;
    return w;
  endfunction

endpackage

// File: rtl/irgate_regs.sv
module irgate_regs
  import irgate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output link_cfg_t         link_q_o,
  output logic [REG_W-1:0]  nphy_q_o,
  output logic              gate_q_o,
  output logic              rise_o
);

  link_cfg_t        link_q;
  logic [REG_W-1:0] nphy_q;
  logic             gate_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      link_q <= '0;
      nphy_q <= '0;
      gate_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        OFS_LINK:  link_q <= unpack_link(wr_data_i);
        OFS_GATE:  gate_q <= wr_data_i[SB_GATE];
        OFS_NXPHY: nphy_q <= wr_data_i;
        default:   ;
      endcase
    end
  end

  // a 0-to-1 edge of the gate is a write of 1 while the gate is 0
  assign rise_o   = wr_en_i && (wr_addr_i == OFS_GATE) && wr_data_i[SB_GATE] && !gate_q;
  assign link_q_o = link_q;
  assign nphy_q_o = nphy_q;
  assign gate_q_o = gate_q;

endmodule

// File: rtl/irgate_apply.sv
module irgate_apply
  import irgate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  link_cfg_t        link_i,
  input  logic [REG_W-1:0] nphy_i,
  output link_cfg_t        act_link_o,
  output logic [REG_W-1:0] act_phy_o
);

  link_cfg_t        act_link;
  logic [REG_W-1:0] act_phy;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      act_link <= '0;
      act_phy  <= '0;
    end else if (rise_i) begin
      act_link <= link_i;
      act_phy  <= nphy_i;
    end
  end

  assign act_link_o = act_link;
  assign act_phy_o  = act_phy;

endmodule

// File: rtl/irgate_status.sv
module irgate_status
  import irgate_pkg::*;
(
  input  logic      gate_i,
  input  link_cfg_t act_i,
  input  logic      pend_entx_i,
  input  logic      pend_enrx_i,
  input  logic      pend_loop_i,
  output logic      sir_o,
  output logic      mir_o,
  output logic      fir_o,
  output logic      err_o,
  output logic      crc_on_o,
  output logic      tx_en_o,
  output logic      rx_en_o,
  output logic [7:0] stat_hi_o
);

  logic [1:0] mode_cnt;
  logic       conflict;
  logic       pass;

  always_comb begin
    mode_cnt = {1'b0, act_i.sir} + {1'b0, act_i.mir} + {1'b0, act_i.fir};
    conflict = (mode_cnt > 2'd1);
    err_o    = gate_i && conflict;
    pass     = gate_i && !conflict;
    sir_o    = pass && act_i.sir;
    mir_o    = pass && act_i.mir;
    fir_o    = pass && act_i.fir;
    crc_on_o = gate_i && act_i.crc16;
    tx_en_o  = gate_i && act_i.entx;
    rx_en_o  = gate_i && act_i.enrx && (!act_i.entx || act_i.loop);

    stat_hi_o                = '0;
    stat_hi_o[SB_GATE-8]     = gate_i;
    stat_hi_o[SB_ERR-8]      = err_o;
    stat_hi_o[SB_FIRON-8]    = fir_o;
    stat_hi_o[SB_MIRON-8]    = mir_o;
    stat_hi_o[SB_SIRON-8]    = sir_o;
    stat_hi_o[SB_TXST-8]     = pend_entx_i;
    stat_hi_o[SB_RXST-8]     = pend_enrx_i && (!pend_entx_i || pend_loop_i);
    stat_hi_o[SB_CRCON-8]    = crc_on_o;
  end

endmodule

// File: rtl/irgate_top.sv
module irgate_top
  import irgate_pkg::*;
#(
  parameter int BAUD_W = 6,
  parameter int PW_W   = 5,
  parameter int PRE_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [irgate_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic [irgate_pkg::REG_W-1:0]  wr_data_i,
  input  logic [irgate_pkg::ADDR_W-1:0] rd_addr_i,
  output logic [irgate_pkg::REG_W-1:0]  rd_data_o,
  output logic                      mode_sir_o,
  output logic                      mode_mir_o,
  output logic                      mode_fir_o,
  output logic                      crc16_o,
  output logic                      tx_en_o,
  output logic                      rx_en_o,
  output logic                      loop_o,
  output logic                      tx_inv_o,
  output logic                      rx_inv_o,
  output logic                      sir_filt_o,
  output logic                      sir_filt_any_o,
  output logic                      rx_any_o,
  output logic                      bus_master_o,
  output logic [BAUD_W-1:0]         baud_div_o,
  output logic [PW_W-1:0]           pulse_w_o,
  output logic [PRE_W-1:0]          preamble_o,
  output logic                      cfg_err_o
);

  localparam int PHY_W   = BAUD_W + PW_W + PRE_W;
  localparam int PW_LSB  = PRE_W;
  localparam int BD_LSB  = PRE_W + PW_W;

  link_cfg_t        link_q;
  link_cfg_t        act_link;
  logic [REG_W-1:0] nphy_q;
  logic [REG_W-1:0] cur_phy;
  logic             gate_q;
  logic             rise;
  logic [7:0]       stat_hi;

  irgate_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .link_q_o  (link_q),
    .nphy_q_o  (nphy_q),
    .gate_q_o  (gate_q),
    .rise_o    (rise)
  );

  irgate_apply u_apply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .link_i     (link_q),
    .nphy_i     (nphy_q),
    .act_link_o (act_link),
    .act_phy_o  (cur_phy)
  );

  irgate_status u_status (
    .gate_i      (gate_q),
    .act_i       (act_link),
    .pend_entx_i (link_q.entx),
    .pend_enrx_i (link_q.enrx),
    .pend_loop_i (link_q.loop),
    .sir_o       (mode_sir_o),
    .mir_o       (mode_mir_o),
    .fir_o       (mode_fir_o),
    .err_o       (cfg_err_o),
    .crc_on_o    (crc16_o),
    .tx_en_o     (tx_en_o),
    .rx_en_o     (rx_en_o),
    .stat_hi_o   (stat_hi)
  );

  // remaining applied fields, gated by the enable
  assign loop_o         = gate_q && act_link.loop;
  assign tx_inv_o       = gate_q && act_link.txinv;
  assign rx_inv_o       = gate_q && act_link.rxinv;
  assign sir_filt_o     = gate_q && act_link.sirfilt;
  assign sir_filt_any_o = gate_q && act_link.sirtest;
  assign rx_any_o       = gate_q && act_link.rxany;
  assign bus_master_o   = gate_q && act_link.mstr;

  generate
    if (PHY_W == REG_W) begin : g_phy_fit
      assign baud_div_o = cur_phy[BD_LSB +: BAUD_W];
      assign pulse_w_o  = cur_phy[PW_LSB +: PW_W];
      assign preamble_o = cur_phy[0 +: PRE_W];
    end else begin : g_phy_bad
      initial $error("irgate_top: physical-layer fields must fill one register");
      assign baud_div_o = '0;
      assign pulse_w_o  = '0;
      assign preamble_o = '0;
    end
  endgenerate

  always_comb begin
    case (rd_addr_i)
      OFS_LINK:   rd_data_o = pack_link(link_q);
      OFS_GATE:   rd_data_o = {stat_hi, 8'h00};
      OFS_NXPHY:  rd_data_o = nphy_q;
      default:    rd_data_o = cur_phy;
    endcase
  end

endmodule

// File: rtl/irgate_chk.sv
module irgate_chk
  import irgate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic [REG_W-1:0] cur_phy,
  input logic [REG_W-1:0] nxt_phy,
  input logic             err,
  input logic             sir,
  input logic             mir,
  input logic             fir,
  input logic             tx_en,
  input logic             rx_en
);

  // R4: applied word equals the pending word at the gate edge
  a_r4_apply_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> cur_phy == $past(nxt_phy));

  // R5: no change of the applied word while the gate stays set
  a_r5_hold_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate) && gate) |-> $stable(cur_phy));

  // R6: gate off means no mode output
  a_r6_off_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !(sir || mir || fir || tx_en || rx_en));

  // R7: error forces modes off, and at most one mode is ever on
  a_r7_err_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(sir || mir || fir));

  a_r7_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sir, mir, fir}));

  // R6: clearing the gate drops modes at once
  a_r6_fall_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> !(sir || mir || fir));

endmodule

bind irgate_top irgate_chk u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .gate    (gate_q),
  .cur_phy (cur_phy),
  .nxt_phy (nphy_q),
  .err     (cfg_err_o),
  .sir     (mode_sir_o),
  .mir     (mode_mir_o),
  .fir     (mode_fir_o),
  .tx_en   (tx_en_o),
  .rx_en   (rx_en_o)
);

// File: tb/irgate_tb.sv
`timescale 1ns/1ps
module irgate_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic sir_o, mir_o, fir_o, crc_o, txe_o, rxe_o, loop_o, txi_o, rxi_o;
  logic sf_o, sfa_o, rxa_o, bm_o, err_o;
  logic [5:0] baud_o;
  logic [4:0] pw_o, pre_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irgate_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mode_sir_o(sir_o), .mode_mir_o(mir_o), .mode_fir_o(fir_o),
    .crc16_o(crc_o), .tx_en_o(txe_o), .rx_en_o(rxe_o), .loop_o(loop_o),
    .tx_inv_o(txi_o), .rx_inv_o(rxi_o), .sir_filt_o(sf_o),
    .sir_filt_any_o(sfa_o), .rx_any_o(rxa_o), .bus_master_o(bm_o),
    .baud_div_o(baud_o), .pulse_w_o(pw_o), .preamble_o(pre_o),
    .cfg_err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [15:0] exp_status(input bit gate, input bit s, input bit m,
      input bit f, input bit crc, input bit tx, input bit rx, input bit lp);
    logic [15:0] e;
    bit er;
    er = gate && ((int'(s) + int'(m) + int'(f)) > 1);
    e = '0;
    e[15] = gate;
    e[14] = er;
    e[13] = gate && !er && f;
    e[12] = gate && !er && m;
    e[11] = gate && !er && s;
    e[10] = tx;
    e[9]  = rx && (!tx || lp);
    e[8]  = gate && crc;
    return e;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] phy_prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d == 16'h0, "R1 reset register", d, 0);
    end
    chk({sir_o,mir_o,fir_o,crc_o,txe_o,rxe_o,loop_o,txi_o,rxi_o,sf_o,sfa_o,rxa_o,bm_o,err_o} == '0,
        "R1 reset outputs", {sir_o,mir_o,fir_o,crc_o,txe_o,rxe_o,loop_o}, 0);
    chk({baud_o,pw_o,pre_o} == '0, "R1 reset phy outputs", {baud_o,pw_o,pre_o}, 0);

    // R2: link word mask
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d);
    chk(d == 16'h5EFF, "R2 link readback mask", d, 16'h5EFF);
    wr(2'd0, 16'h0000);
    rd(2'd0, d);
    chk(d == 16'h0000, "R2 link clear", d, 0);

    // R3: pending phy full width; current phy read-only
    wr(2'd2, 16'hA5C3);
    rd(2'd2, d);
    chk(d == 16'hA5C3, "R3 next phy readback", d, 16'hA5C3);
    wr(2'd3, 16'h1234);
    rd(2'd3, d);
    chk(d == 16'h0000, "R3 current phy ignores write", d, 0);

    // R9: gate register ignores bits other than 15
    wr(2'd1, 16'h7FFF);
    rd(2'd1, d);
    chk(d == 16'h0000, "R9 status ignores non-gate bits", d, 0);
    chk(sir_o == 0 && mir_o == 0 && fir_o == 0, "R9 no gate after non-gate write", {sir_o,mir_o,fir_o}, 0);

    // Sweep: all combinations of mode, crc, tx, rx, loop
    phy_prev = 16'h0000;
    for (int c = 0; c < 128; c++) begin
      bit s, m, f, crc, tx, rx, lp, er, rxs;
      logic [15:0] lw, pw;
      s = c[0]; m = c[1]; f = c[2]; crc = c[3]; tx = c[4]; rx = c[5]; lp = c[6];
      lw = '0;
      lw[4] = s; lw[5] = m; lw[6] = f; lw[7] = crc; lw[12] = tx; lw[11] = rx; lw[14] = lp;
      lw[1] = s ^ f; lw[0] = m; lw[3] = crc ^ lp; lw[2] = tx; lw[9] = rx ^ s; lw[10] = c[0] ^ c[4];
      pw = {c[5:0], c[4:0] ^ 5'h15, c[6:2]};
      er = (int'(s) + int'(m) + int'(f)) > 1;
      rxs = rx && (!tx || lp);

      wr(2'd1, 16'h0000);
      chk(!(sir_o || mir_o || fir_o), "R6 modes off after gate clear", {sir_o,mir_o,fir_o}, 0);
      wr(2'd0, lw);
      wr(2'd2, pw);
      rd(2'd1, d);
      chk(d == exp_status(0, s, m, f, crc, tx, rx, lp), "R8 live status with gate off",
          d, exp_status(0, s, m, f, crc, tx, rx, lp));
      rd(2'd3, d);
      chk(d == phy_prev, "R5 current phy not yet applied", d, phy_prev);

      wr(2'd1, 16'h8000);
      rd(2'd1, d);
      chk(d == exp_status(1, s, m, f, crc, tx, rx, lp), "R7 R9 status after gate edge",
          d, exp_status(1, s, m, f, crc, tx, rx, lp));
      rd(2'd3, d);
      chk(d == pw, "R4 current phy applied", d, pw);
      chk({baud_o, pw_o, pre_o} == pw, "R4 phy outputs", {baud_o, pw_o, pre_o}, pw);
      chk({sir_o, mir_o, fir_o, err_o} == {s && !er, m && !er, f && !er, er},
          "R7 mode outputs", {sir_o, mir_o, fir_o, err_o}, {s && !er, m && !er, f && !er, er});
      chk({txe_o, rxe_o} == {tx, rxs}, "R10 tx/rx enable outputs", {txe_o, rxe_o}, {tx, rxs});
      chk({crc_o, loop_o, txi_o, rxi_o, sf_o, sfa_o, rxa_o, bm_o} ==
          {crc, lp, lw[1], lw[0], lw[3], lw[2], lw[9], lw[10]}, "R4 applied field outputs",
          {crc_o, loop_o, txi_o, rxi_o, sf_o, sfa_o, rxa_o, bm_o},
          {crc, lp, lw[1], lw[0], lw[3], lw[2], lw[9], lw[10]});
      phy_prev = pw;
    end

    // R5: writes while gate is on are stored but not applied
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0010);            // SIR only
    wr(2'd2, 16'h0C00);
    wr(2'd1, 16'h8000);
    chk(sir_o == 1 && fir_o == 0, "R4 SIR applied", {sir_o, fir_o}, 2'b10);
    wr(2'd0, 16'h1040);            // FIR + tx enable, stored only
    wr(2'd2, 16'h000F);
    rd(2'd0, d);
    chk(d == 16'h1040, "R5 pending link stored while on", d, 16'h1040);
    rd(2'd3, d);
    chk(d == 16'h0C00, "R5 current phy held while on", d, 16'h0C00);
    chk(sir_o == 1 && fir_o == 0 && txe_o == 0, "R5 outputs held while on", {sir_o, fir_o, txe_o}, 3'b100);
    rd(2'd1, d);
    chk(d[10] == 1'b1, "R8 tx status follows pending while on", d[10], 1);
    wr(2'd1, 16'h8000);            // re-write 1 while on: no edge
    rd(2'd3, d);
    chk(d == 16'h0C00, "R5 repeated set is not an edge", d, 16'h0C00);
    wr(2'd1, 16'h0000);
    chk(sir_o == 0 && fir_o == 0, "R6 drop on clear", {sir_o, fir_o}, 0);
    rd(2'd3, d);
    chk(d == 16'h0C00, "R6 current phy kept after clear", d, 16'h0C00);
    wr(2'd1, 16'h8000);
    rd(2'd3, d);
    chk(d == 16'h000F, "R5 applied at next edge", d, 16'h000F);
    chk(fir_o == 1 && sir_o == 0 && txe_o == 1, "R5 new mode at next edge", {fir_o, sir_o, txe_o}, 3'b101);

    // R1: reset clears applied state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd3, d);
    chk(d == 16'h0, "R1 reset clears current phy", d, 0);
    rd(2'd1, d);
    chk(d == 16'h0, "R1 reset clears status", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule